// File: doc/BRIEF.md
# Per-Channel Qubit Readout Classifier

This block turns one integrated I/Q readout value into a qubit state decision, |0⟩ or |1⟩. A small neural network in 16-bit fixed point makes the decision. Several readout channels share one pipelined datapath. Each sample arrives with its channel index, and the block applies only that channel's stored parameter set. A set holds the input offsets and scales, the hidden-layer weights and biases, and the output weights and bias. Because each channel has its own set, a set can include compensation for crosstalk from neighbouring channels that was learned offline.

The pipeline has three register stages: normalisation, a hidden layer with rectified-linear activation, and a single output neuron. The output neuron's pre-activation is compared with zero. The block accepts one sample on every clock and returns each decision a fixed number of cycles later, together with its channel index. A word-wide write port loads the parameters. It addresses a channel, a layer, a neuron and an index. A write to a channel is dropped while any sample of that channel is still reading parameters, so an inference never sees a half-updated set.

Top module: `qro_classifier`

## Requirements
- R1: After reset, `out_valid` is 0 and every stored parameter is zero. With an all-zero set, a sample's output value is 0, so `out_state` is 1.
- R2: A sample accepted on a clock edge (`in_valid` = 1) produces `out_valid` = 1 during the cycle that follows the third edge counted from and including that edge. Samples on consecutive cycles produce decisions on consecutive cycles, and `out_valid` is 0 at all other times.
- R3: `out_ch` equals the `in_ch` of the sample that the decision belongs to.
- R4: Normalisation computes n = S(R((x − offset) · scale)) separately for I and for Q. R(a) = floor((a + 2048) / 4096). S clamps to the range −32768..32767. Offsets and scales are 16-bit signed. Scales are Q4.12.
- R5: Each hidden neuron j computes h_j = max(0, S(R(wI_j·nI + wQ_j·nQ + b_j·4096))). No intermediate sum wraps.
- R6: The output value is y = S(R(Σ_j wo_j·h_j + bo·4096)). `out_state` is 1 when y ≥ 0 and 0 when y < 0.
- R7: Every sample is computed with the parameter set of its own `in_ch`, whatever the samples of other channels in the pipeline use.
- R8: A write's target is chosen by `wr_layer` and `wr_idx`, with `wr_neuron` selecting the neuron where a layer has one:
  - Layer 0: index 0 is the I offset, 1 the Q offset, 2 the I scale and 3 the Q scale.
  - Layer 1: for neuron `wr_neuron`, index 0 is wI, 1 is wQ and 2 is the bias.
  - Layer 2: index 0 is wo of hidden neuron `wr_neuron`, and index 1 is the output bias.
  - Every other combination changes nothing.
- R9: A write to channel c is ignored when `in_valid` is 1 with `in_ch` = c on the same edge, or when a sample of channel c was accepted on either of the two preceding edges. Writes to other channels take effect at once.
- R10: Saturation is applied at each stage, so extreme inputs and parameters give clamped intermediate values rather than wrapped ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_ch | input | CH_W | Channel index of the sample |
| in_i | input | 16 | Integrated in-phase value, signed |
| in_q | input | 16 | Integrated quadrature value, signed |
| wr_en | input | 1 | Parameter write strobe |
| wr_ch | input | CH_W | Channel whose set is written |
| wr_layer | input | 2 | Layer select (0 normalise, 1 hidden, 2 output) |
| wr_neuron | input | NH_W | Neuron select |
| wr_idx | input | 2 | Word select within the neuron |
| wr_data | input | 16 | Parameter value, signed |
| out_valid | output | 1 | Decision strobe |
| out_ch | output | CH_W | Channel index of the decision |
| out_state | output | 1 | 1 for the excited state, 0 for the ground state |

## Verification
The timing and channel properties assume the following about the inputs:
- `in_valid` and `in_ch` are fully defined on every cycle after reset.
- `in_ch` always names an existing channel.
- Reset is held for at least one edge.

The stimulus drives every input to a known value on every cycle, including idle ones. It draws channel indices only from 0 to NCH−1. Random parameter writes, including some to unused layer and index codes, are interleaved with back-to-back traffic. This makes writes collide with in-flight samples of the same channel in every pipeline position.

// File: rtl/qro_pkg.sv
`timescale 1ns/1ps
package qro_pkg;
    localparam int DW    = 16;
    localparam int FRAC  = 12;
    localparam int ACC_W = 40;

    typedef logic signed [DW-1:0]    word_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    typedef enum logic [1:0] {
        LY_NORM = 2'd0,
        LY_HID  = 2'd1,
        LY_OUT  = 2'd2,
        LY_NONE = 2'd3
    } layer_e;

    localparam acc_t SAT_HI = acc_t'(32767);
    localparam acc_t SAT_LO = acc_t'(-32768);

    function automatic acc_t widen(input word_t x);
        return acc_t'(x);
    endfunction

    // round half up at the Q4.12 point, then clamp to a signed word
    function automatic word_t rnd_sat(input acc_t a);
        acc_t r;
        r = (a + acc_t'(1 <<< (FRAC - 1))) >>> FRAC;
        if (r > SAT_HI) return word_t'(SAT_HI);
        if (r < SAT_LO) return word_t'(SAT_LO);
        return word_t'(r);
    endfunction
endpackage

// File: rtl/qro_wbank.sv
`timescale 1ns/1ps
module qro_wbank
    import qro_pkg::*;
#(
    parameter int NCH = 4,
    parameter int NH  = 8,
    localparam int CH_W = $clog2(NCH),
    localparam int NH_W = $clog2(NH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CH_W-1:0]    wr_ch,
    input  layer_e             wr_layer,
    input  logic [NH_W-1:0]    wr_neuron,
    input  logic [1:0]         wr_idx,
    input  word_t              wr_data,
    input  logic [CH_W-1:0]    rd_n_ch,
    input  logic [CH_W-1:0]    rd_h_ch,
    input  logic [CH_W-1:0]    rd_o_ch,
    output word_t              off_i,
    output word_t              off_q,
    output word_t              sc_i,
    output word_t              sc_q,
    output word_t [NH-1:0]     h_wi,
    output word_t [NH-1:0]     h_wq,
    output word_t [NH-1:0]     h_b,
    output word_t [NH-1:0]     o_w,
    output word_t              o_b
);
    typedef struct packed {
        word_t          oi;
        word_t          oq;
        word_t          si;
        word_t          sq;
        word_t [NH-1:0] wi;
        word_t [NH-1:0] wq;
        word_t [NH-1:0] bh;
        word_t [NH-1:0] wo;
        word_t          bo;
    } chset_t;

    chset_t [NCH-1:0] bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en && (int'(wr_ch) < NCH) && (int'(wr_neuron) < NH)) begin
            unique case (wr_layer)
                LY_NORM: begin
                    case (wr_idx)
                        2'd0: bank_d[wr_ch].oi = wr_data;
                        2'd1: bank_d[wr_ch].oq = wr_data;
                        2'd2: bank_d[wr_ch].si = wr_data;
                        default: bank_d[wr_ch].sq = wr_data;
                    endcase
                end
                LY_HID: begin
                    case (wr_idx)
                        2'd0: bank_d[wr_ch].wi[wr_neuron] = wr_data;
                        2'd1: bank_d[wr_ch].wq[wr_neuron] = wr_data;
                        2'd2: bank_d[wr_ch].bh[wr_neuron] = wr_data;
                        default: ;
                    endcase
                end
                LY_OUT: begin
                    case (wr_idx)
                        2'd0: bank_d[wr_ch].wo[wr_neuron] = wr_data;
                        2'd1: bank_d[wr_ch].bo = wr_data;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign off_i = bank_q[rd_n_ch].oi;
    assign off_q = bank_q[rd_n_ch].oq;
    assign sc_i  = bank_q[rd_n_ch].si;
    assign sc_q  = bank_q[rd_n_ch].sq;
    assign h_wi  = bank_q[rd_h_ch].wi;
    assign h_wq  = bank_q[rd_h_ch].wq;
    assign h_b   = bank_q[rd_h_ch].bh;
    assign o_w   = bank_q[rd_o_ch].wo;
    assign o_b   = bank_q[rd_o_ch].bo;
endmodule

// File: rtl/qro_norm.sv
`timescale 1ns/1ps
module qro_norm
    import qro_pkg::*;
#(
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_v,
    input  logic [CH_W-1:0] in_ch,
    input  word_t           x_i,
    input  word_t           x_q,
    input  word_t           off_i,
    input  word_t           off_q,
    input  word_t           sc_i,
    input  word_t           sc_q,
    output logic            out_v,
    output logic [CH_W-1:0] out_ch,
    output word_t           n_i,
    output word_t           n_q
);
    typedef struct packed {
        logic            v;
        logic [CH_W-1:0] ch;
        word_t           ni;
        word_t           nq;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.v  = in_v;
        st_d.ch = in_ch;
        st_d.ni = rnd_sat((widen(x_i) - widen(off_i)) * widen(sc_i));
        st_d.nq = rnd_sat((widen(x_q) - widen(off_q)) * widen(sc_q));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_v  = st_q.v;
    assign out_ch = st_q.ch;
    assign n_i    = st_q.ni;
    assign n_q    = st_q.nq;
endmodule

// File: rtl/qro_hidden.sv
`timescale 1ns/1ps
module qro_hidden
    import qro_pkg::*;
#(
    parameter int NH   = 8,
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_v,
    input  logic [CH_W-1:0] in_ch,
    input  word_t           n_i,
    input  word_t           n_q,
    input  word_t [NH-1:0]  wi,
    input  word_t [NH-1:0]  wq,
    input  word_t [NH-1:0]  bh,
    output logic            out_v,
    output logic [CH_W-1:0] out_ch,
    output word_t [NH-1:0]  h
);
    typedef struct packed {
        logic            v;
        logic [CH_W-1:0] ch;
        word_t [NH-1:0]  h;
    } st_t;

    st_t st_d, st_q;
    word_t [NH-1:0] act;

    for (genvar j = 0; j < NH; j++) begin : g_neu
        acc_t  pre;
        word_t lim;
        assign pre = widen(wi[j]) * widen(n_i) + widen(wq[j]) * widen(n_q)
                   + (widen(bh[j]) <<< FRAC);
        assign lim = rnd_sat(pre);
        assign act[j] = lim[DW-1] ? '0 : lim;
    end

    always_comb begin
        st_d.v  = in_v;
        st_d.ch = in_ch;
        st_d.h  = act;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_v  = st_q.v;
    assign out_ch = st_q.ch;
    assign h      = st_q.h;
endmodule

// File: rtl/qro_outlayer.sv
`timescale 1ns/1ps
module qro_outlayer
    import qro_pkg::*;
#(
    parameter int NH   = 8,
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_v,
    input  logic [CH_W-1:0] in_ch,
    input  word_t [NH-1:0]  h,
    input  word_t [NH-1:0]  wo,
    input  word_t           bo,
    output logic            out_v,
    output logic [CH_W-1:0] out_ch,
    output logic            out_st
);
    typedef struct packed {
        logic            v;
        logic [CH_W-1:0] ch;
        logic            st;
    } st_t;

    st_t   st_d, st_q;
    acc_t  sum_c;
    word_t y_c;

    always_comb begin
        sum_c = widen(bo) <<< FRAC;
        for (int j = 0; j < NH; j++) begin
            sum_c = sum_c + widen(wo[j]) * widen(h[j]);
        end
        y_c     = rnd_sat(sum_c);
        st_d.v  = in_v;
        st_d.ch = in_ch;
        st_d.st = ~y_c[DW-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_v  = st_q.v;
    assign out_ch = st_q.ch;
    assign out_st = st_q.st;
endmodule

// File: rtl/qro_classifier.sv
`timescale 1ns/1ps
module qro_classifier
    import qro_pkg::*;
#(
    parameter int NCH = 4,
    parameter int NH  = 8,
    localparam int CH_W = $clog2(NCH),
    localparam int NH_W = $clog2(NH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [CH_W-1:0]    in_ch,
    input  logic signed [15:0] in_i,
    input  logic signed [15:0] in_q,
    input  logic               wr_en,
    input  logic [CH_W-1:0]    wr_ch,
    input  logic [1:0]         wr_layer,
    input  logic [NH_W-1:0]    wr_neuron,
    input  logic [1:0]         wr_idx,
    input  logic signed [15:0] wr_data,
    output logic               out_valid,
    output logic [CH_W-1:0]    out_ch,
    output logic               out_state
);
    logic            n_v, h_v, wr_busy;
    logic [CH_W-1:0] n_ch, h_ch;
    word_t           off_i, off_q, sc_i, sc_q, o_b, n_i, n_q;
    word_t [NH-1:0]  h_wi, h_wq, h_b, o_w, h_act;

    // every stage that still has to read parameters holds the channel busy
    assign wr_busy = (in_valid && in_ch == wr_ch) || (n_v && n_ch == wr_ch)
                   || (h_v && h_ch == wr_ch);

    qro_wbank #(.NCH(NCH), .NH(NH)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en && !wr_busy), .wr_ch(wr_ch),
        .wr_layer(layer_e'(wr_layer)), .wr_neuron(wr_neuron), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_n_ch(in_ch), .rd_h_ch(n_ch), .rd_o_ch(h_ch),
        .off_i(off_i), .off_q(off_q), .sc_i(sc_i), .sc_q(sc_q),
        .h_wi(h_wi), .h_wq(h_wq), .h_b(h_b), .o_w(o_w), .o_b(o_b)
    );

    qro_norm #(.CH_W(CH_W)) u_norm (
        .clk(clk), .rst_n(rst_n), .in_v(in_valid), .in_ch(in_ch),
        .x_i(in_i), .x_q(in_q), .off_i(off_i), .off_q(off_q),
        .sc_i(sc_i), .sc_q(sc_q), .out_v(n_v), .out_ch(n_ch),
        .n_i(n_i), .n_q(n_q)
    );

    qro_hidden #(.NH(NH), .CH_W(CH_W)) u_hid (
        .clk(clk), .rst_n(rst_n), .in_v(n_v), .in_ch(n_ch),
        .n_i(n_i), .n_q(n_q), .wi(h_wi), .wq(h_wq), .bh(h_b),
        .out_v(h_v), .out_ch(h_ch), .h(h_act)
    );

    qro_outlayer #(.NH(NH), .CH_W(CH_W)) u_out (
        .clk(clk), .rst_n(rst_n), .in_v(h_v), .in_ch(h_ch),
        .h(h_act), .wo(o_w), .bo(o_b),
        .out_v(out_valid), .out_ch(out_ch), .out_st(out_state)
    );
endmodule

// File: rtl/qro_checker.sv
`timescale 1ns/1ps
module qro_checker #(
    parameter int CH_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [CH_W-1:0] in_ch,
    input logic            out_valid,
    input logic [CH_W-1:0] out_ch,
    input logic            out_state
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (!rst_n)                  since_rst <= 2'd0;
        else if (since_rst != 2'd3)  since_rst <= since_rst + 2'd1;
    end

    a_r2_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    a_r2_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd3) |-> !out_valid);

    a_r3_channel_carried: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && out_valid) |-> (out_ch == $past(in_ch, 3)));

    a_r6_state_defined: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_state));
endmodule

bind qro_classifier qro_checker #(.CH_W(CH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ch(in_ch),
    .out_valid(out_valid), .out_ch(out_ch), .out_state(out_state)
);

// File: tb/sim_qro_classifier.sv
`timescale 1ns/1ps
module sim_qro_classifier;
    localparam int NCH = 4;
    localparam int NH  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [1:0]        in_ch = '0;
    logic signed [15:0] in_i = '0, in_q = '0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_ch = '0, wr_layer = '0, wr_idx = '0;
    logic [2:0]        wr_neuron = '0;
    logic signed [15:0] wr_data = '0;
    logic              out_valid, out_state;
    logic [1:0]        out_ch;

    always #2 clk = ~clk;

    qro_classifier #(.NCH(NCH), .NH(NH)) u0 (.*);

    // behavioural parameter mirror
    longint m_oi[NCH], m_oq[NCH], m_si[NCH], m_sq[NCH], m_bo[NCH];
    longint m_wi[NCH][NH], m_wq[NCH][NH], m_bh[NCH][NH], m_wo[NCH][NH];

    typedef struct { int due; int ch; int st; } exp_t;
    exp_t pend[$];
    int cyc = 0, n_cmp = 0, n_bad = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic longint rs(longint a);
        longint r;
        r = (a + 2048) >>> 12;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    function automatic int predict(int ch, longint xi, longint xq);
        longint ni, nq, h, acc;
        ni  = rs((xi - m_oi[ch]) * m_si[ch]);
        nq  = rs((xq - m_oq[ch]) * m_sq[ch]);
        acc = m_bo[ch] * 4096;
        for (int j = 0; j < NH; j++) begin
            h = rs(m_wi[ch][j] * ni + m_wq[ch][j] * nq + m_bh[ch][j] * 4096);
            if (h < 0) h = 0;
            acc += m_wo[ch][j] * h;
        end
        return (rs(acc) >= 0) ? 1 : 0;
    endfunction

    task automatic compare(string tag);
        bit ev;
        ev = (pend.size() > 0) && (pend[0].due == cyc);
        n_cmp++;
        if (out_valid !== ev) begin
            n_bad++;
            $display("FAIL R2 %s cyc %0d out_valid %b expected %b", tag, cyc, out_valid, ev);
        end
        if (ev) begin
            if (out_ch !== 2'(pend[0].ch)) begin
                n_bad++;
                $display("FAIL R3 %s out_ch %0d expected %0d", tag, out_ch, pend[0].ch);
            end
            if (out_state !== 1'(pend[0].st)) begin
                n_bad++;
                $display("FAIL R7 %s ch %0d out_state %b expected %0d", tag, pend[0].ch, out_state, pend[0].st);
            end
            void'(pend.pop_front());
        end
    endtask

    task automatic mirror_write(int c, int l, int n, int x, longint d);
        case (l)
            0: case (x) 0: m_oi[c] = d; 1: m_oq[c] = d; 2: m_si[c] = d; default: m_sq[c] = d; endcase
            1: case (x) 0: m_wi[c][n] = d; 1: m_wq[c][n] = d; 2: m_bh[c][n] = d; default: ; endcase
            2: case (x) 0: m_wo[c][n] = d; 1: m_bo[c] = d; default: ; endcase
            default: ;
        endcase
    endtask

    // one clock: check outputs, then drive the next edge's inputs
    task automatic step(bit v, int ch, int xi, int xq, bit we, int wc, int wl, int wn, int wx, int wd, string tag);
        bit busy;
        @(negedge clk);
        compare(tag);
        in_valid = v; in_ch = 2'(ch); in_i = 16'(xi); in_q = 16'(xq);
        wr_en = we; wr_ch = 2'(wc); wr_layer = 2'(wl); wr_neuron = 3'(wn);
        wr_idx = 2'(wx); wr_data = 16'(wd);
        if (v) pend.push_back('{due: cyc + 3, ch: ch, st: predict(ch, xi, xq)});
        if (we) begin
            busy = 1'b0;
            foreach (pend[k]) if (pend[k].ch == wc) busy = 1'b1;  // R9 in-flight window
            if (!busy) mirror_write(wc, wl, wn, wx, longint'(16'(wd) == 16'(wd) ? $signed(16'(wd)) : 0));
        end
    endtask

    task automatic idle(int k, string tag);
        for (int i = 0; i < k; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    function automatic int rnd(int lo, int hi);
        return lo + int'($urandom_range(hi - lo));
    endfunction

    task automatic program_channel(int c);
        step(0,0,0,0, 1, c, 0, 0, 0, rnd(-600, 600), "R8");
        step(0,0,0,0, 1, c, 0, 0, 1, rnd(-600, 600), "R8");
        step(0,0,0,0, 1, c, 0, 0, 2, rnd(2048, 8192), "R8");
        step(0,0,0,0, 1, c, 0, 0, 3, rnd(2048, 8192), "R8");
        for (int j = 0; j < NH; j++) begin
            step(0,0,0,0, 1, c, 1, j, 0, rnd(-6000, 6000), "R8");
            step(0,0,0,0, 1, c, 1, j, 1, rnd(-6000, 6000), "R8");
            step(0,0,0,0, 1, c, 1, j, 2, rnd(-500, 500), "R8");
            step(0,0,0,0, 1, c, 2, j, 0, rnd(-6000, 6000), "R8");
        end
        step(0,0,0,0, 1, c, 2, 0, 1, rnd(-800, 800), "R8");
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_oi[c] = 0; m_oq[c] = 0; m_si[c] = 0; m_sq[c] = 0; m_bo[c] = 0;
            for (int j = 0; j < NH; j++) begin
                m_wi[c][j] = 0; m_wq[c][j] = 0; m_bh[c][j] = 0; m_wo[c][j] = 0;
            end
        end
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet outputs and all-zero sets decide state 1
        idle(3, "R1");
        for (int c = 0; c < NCH; c++) step(1, c, rnd(-9000, 9000), rnd(-9000, 9000), 0,0,0,0,0,0, "R1");
        idle(4, "R1");
        // R8: load every channel, including writes to unused codes
        for (int c = 0; c < NCH; c++) program_channel(c);
        step(0,0,0,0, 1, 1, 3, 2, 0, 12345, "R8");
        step(0,0,0,0, 1, 2, 2, 1, 3, -777, "R8");
        step(0,0,0,0, 1, 3, 1, 4, 3, 999, "R8");
        idle(2, "R8");
        // R4 R5 R6 R7: back-to-back mixed channels
        for (int n = 0; n < 2000; n++)
            step(1, rnd(0, NCH - 1), rnd(-4000, 4000), rnd(-4000, 4000), 0,0,0,0,0,0, "R7");
        // R9: a same-channel write in each in-flight position, then after it
        step(1, 1, 1500, -800, 1, 1, 2, 0, 1, -32768, "R9");
        step(0, 0, 0, 0,       1, 1, 2, 0, 1, -32768, "R9");
        step(0, 0, 0, 0,       1, 1, 2, 0, 1, -32768, "R9");
        step(1, 1, 1500, -800, 0,0,0,0,0,0, "R9");
        step(0, 0, 0, 0,       1, 1, 2, 0, 1, 32767, "R9");
        step(1, 1, 1500, -800, 1, 2, 2, 0, 1, -32768, "R9");
        idle(4, "R9");
        // R9: random writes mixed with traffic
        for (int n = 0; n < 3000; n++)
            step($urandom_range(1) == 1, rnd(0, NCH - 1), rnd(-4000, 4000), rnd(-4000, 4000),
                 $urandom_range(2) == 0, rnd(0, NCH - 1), rnd(0, 3), rnd(0, NH - 1), rnd(0, 3),
                 rnd(-6000, 6000), "R9");
        // R10: extremes drive every stage into its clamps
        for (int c = 0; c < NCH; c++) begin
            step(0,0,0,0, 1, c, 0, 0, 2, 32767, "R10");
            step(0,0,0,0, 1, c, 0, 0, 3, -32768, "R10");
        end
        idle(3, "R10");
        for (int n = 0; n < 200; n++)
            step(1, rnd(0, NCH - 1), (n % 2 == 0) ? 32767 : -32768, rnd(-32768, 32767), 0,0,0,0,0,0, "R10");
        idle(6, "R10");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired at cyc %0d, expected completion", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule